// File: doc/BRIEF.md
# Prescaled 64-bit Deadline Timer

This block keeps a 64-bit time base that advances once per prescaler period and compares it against four 64-bit deadlines. A 16-bit prescaler counts down each clock cycle while counting is enabled. When it sits at zero it reloads from a programmable value, and the time base steps by one. Each deadline has an enable bit and a pending flag. The interrupt line is high while any deadline is both enabled and pending.

Software talks to the block through a plain 32-bit register port: one access per cycle, with a select and a write strobe. Read data appears in the cycle after the read. A full 64-bit deadline moves through a shared high-word holding register, so a deadline can be written or read as one consistent value. There are three other ways to program a deadline. A relative-set write loads "now plus offset". A copy command shifts each selected deadline down from its next neighbour. A cancel command drops a deadline's enable and pending bits together.

Top module: `rt_deadline_timer`

## Requirements
- R1: While counting is enabled, the prescaler count (read/write at 0x00, bits 15:0) decreases by one per clock. When it is zero, it reloads from the reload value and the time base increments by one in the same cycle. A write to 0x00 loads the count directly.
- R2: The reload register at 0x04 keeps only bits 15:0 of the written value. Writing 0xFFFFFFFF reads back as 0x0000FFFF.
- R3: Bit 0 of the control register (read/write at 0x0C) enables counting. While it is 0, neither the prescaler count nor the time base changes.
- R4: The register at 0x08 is read-only and returns the number of deadlines (4) in bits 7:0. Writes to it have no effect.
- R5: Deadline n (n = 0..3) sets pending bit n (read at 0x28) on the clock edge where its enable bit is 1 and the time base is greater than or equal to the deadline value.
- R6: Writing 1 to bit n of 0x28 clears pending bit n. If a new hit occurs in the same cycle, the pending bit stays set.
- R7: The enable register at 0x24 holds one bit per deadline in bits 3:0. The irq output is 1 exactly when some deadline has both its pending bit and its enable bit at 1.
- R8: The holding register at 0x40 is read/write. Reading deadline n's low word at 0x80+8n returns bits 31:0 and copies bits 63:32 into the holding register. Writing that address loads the deadline with {holding register, written word}.
- R9: Writing a word to 0x84+8n loads deadline n with the current time base plus the written word, taken as unsigned.
- R10: Writing 1 to bit n of 0x2C (write-only) loads deadline n with the value deadline n+1 held before the write. Bit 3, for the last deadline, changes nothing.
- R11: Writing 1 to bit n of 0x30 (write-only) clears both enable bit n and pending bit n. This takes priority over a hit in the same cycle.
- R12: After reset, every register and the time base are zero. Reads of the write-only offsets and of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq | output | 1 | OR over deadlines of pending AND enable |

## Verification
The assertions assume that every access lasts a single cycle and that the address is word-aligned; with those two assumptions, each register sees at most one write per edge. The stimulus gives every access one full clock, with inputs changed only at the falling edge, and it uses only aligned offsets from the map. Deadlines are kept small or already in the past, so hits happen inside the run. The reference model mirrors each write as the design sees it, including a hit that lands in the same cycle as a clear.

// File: rtl/rtt_pkg.sv
package rtt_pkg;
    localparam int BUS_W   = 32;
    localparam int ADDR_W  = 8;
    localparam int TIME_W  = 64;

    localparam logic [ADDR_W-1:0] OFS_PCNT   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_RELOAD = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_INFO   = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_ENABLE = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_PEND   = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_COPY   = 8'h2C;
    localparam logic [ADDR_W-1:0] OFS_CANCEL = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_HOLD   = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_DLBASE = 8'h80;
endpackage

// File: rtl/rtt_prescaler.sv
module rtt_prescaler #(
    parameter int PS_W = 16,
    parameter int TW   = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            cnt_wr,
    input  logic            rld_wr,
    input  logic [PS_W-1:0] wval,
    output logic [PS_W-1:0] cnt_q,
    output logic [PS_W-1:0] rld_q,
    output logic [TW-1:0]   time_q
);
    typedef struct packed {
        logic [PS_W-1:0] cnt;
        logic [PS_W-1:0] rld;
        logic [TW-1:0]   tb;
    } ps_t;

    ps_t p_d, p_q;
    logic tick;

    always_comb begin
        p_d  = p_q;
        tick = run && (p_q.cnt == '0);
        if (cnt_wr)
            p_d.cnt = wval;
        else if (run)
            p_d.cnt = tick ? p_q.rld : p_q.cnt - 1'b1;
        if (rld_wr)
            p_d.rld = wval;
        if (tick)
            p_d.tb = p_q.tb + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign cnt_q  = p_q.cnt;
    assign rld_q  = p_q.rld;
    assign time_q = p_q.tb;

    // R1: a running, unwritten nonzero count steps down by one
    a_r1_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cnt_wr && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
    // R3: stopped counting freezes the time base
    a_r3_time_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(time_q));
    // R3: stopped counting freezes an unwritten prescaler
    a_r3_cnt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr) |=> $stable(cnt_q));
endmodule

// File: rtl/rtt_hit_cmp.sv
module rtt_hit_cmp #(
    parameter int N  = 4,
    parameter int TW = 64
) (
    input  logic [TW-1:0]        now,
    input  logic [N-1:0][TW-1:0] dl,
    input  logic [N-1:0]         en,
    output logic [N-1:0]         hit
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit[i] = en[i] && (now >= dl[i]);
    end
endmodule

// File: rtl/rt_deadline_timer.sv
module rt_deadline_timer
    import rtt_pkg::*;
#(
    parameter int NUM_DL = 4,
    parameter int PS_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq
);
    localparam int HALF   = TIME_W / 2;
    localparam int IDX_W  = ADDR_W - 4;

    typedef struct packed {
        logic                        run;
        logic [NUM_DL-1:0]           en;
        logic [NUM_DL-1:0]           pend;
        logic [HALF-1:0]             hold;
        logic [NUM_DL-1:0][TIME_W-1:0] dl;
        logic [BUS_W-1:0]            rdata;
    } st_t;

    st_t s_d, s_q;

    logic                acc_wr, acc_rd;
    logic                cnt_wr, rld_wr;
    logic [PS_W-1:0]     cnt_q, rld_q;
    logic [TIME_W-1:0]   time_q;
    logic [NUM_DL-1:0]   hit, w1c, cxl;
    logic                dl_area, dl_is_set;
    logic [IDX_W-1:0]    dl_idx;

    assign acc_wr    = bus_sel && bus_wr;
    assign acc_rd    = bus_sel && !bus_wr;
    assign cnt_wr    = acc_wr && (bus_addr == OFS_PCNT);
    assign rld_wr    = acc_wr && (bus_addr == OFS_RELOAD);
    assign dl_area   = bus_addr[ADDR_W-1] && (bus_addr[1:0] == 2'b00);
    assign dl_is_set = bus_addr[2];
    assign dl_idx    = bus_addr[ADDR_W-2:3];

    rtt_prescaler #(.PS_W(PS_W), .TW(TIME_W)) u_ps (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (s_q.run),
        .cnt_wr (cnt_wr),
        .rld_wr (rld_wr),
        .wval   (bus_wdata[PS_W-1:0]),
        .cnt_q  (cnt_q),
        .rld_q  (rld_q),
        .time_q (time_q)
    );

    rtt_hit_cmp #(.N(NUM_DL), .TW(TIME_W)) u_cmp (
        .now (time_q),
        .dl  (s_q.dl),
        .en  (s_q.en),
        .hit (hit)
    );

    always_comb begin
        s_d = s_q;
        w1c = '0;
        cxl = '0;
        if (acc_wr) begin
            case (bus_addr)
                OFS_CTRL:   s_d.run  = bus_wdata[0];
                OFS_ENABLE: s_d.en   = bus_wdata[NUM_DL-1:0];
                OFS_PEND:   w1c      = bus_wdata[NUM_DL-1:0];
                OFS_CANCEL: cxl      = bus_wdata[NUM_DL-1:0];
                OFS_HOLD:   s_d.hold = bus_wdata;
                OFS_COPY: begin
                    for (int i = 0; i < NUM_DL - 1; i++)
                        if (bus_wdata[i]) s_d.dl[i] = s_q.dl[i+1];
                end
                default: begin
                    if (dl_area) begin
                        for (int i = 0; i < NUM_DL; i++) begin
                            if (dl_idx == IDX_W'(i)) begin
                                if (dl_is_set)
                                    s_d.dl[i] = time_q + {{HALF{1'b0}}, bus_wdata};
                                else
                                    s_d.dl[i] = {s_q.hold, bus_wdata};
                            end
                        end
                    end
                end
            endcase
        end
        if (acc_rd) begin
            s_d.rdata = '0;
            case (bus_addr)
                OFS_PCNT:   s_d.rdata = BUS_W'(cnt_q);
                OFS_RELOAD: s_d.rdata = BUS_W'(rld_q);
                OFS_INFO:   s_d.rdata = BUS_W'(NUM_DL);
                OFS_CTRL:   s_d.rdata = BUS_W'(s_q.run);
                OFS_ENABLE: s_d.rdata = BUS_W'(s_q.en);
                OFS_PEND:   s_d.rdata = BUS_W'(s_q.pend);
                OFS_HOLD:   s_d.rdata = s_q.hold;
                default: begin
                    if (dl_area && !dl_is_set) begin
                        for (int i = 0; i < NUM_DL; i++) begin
                            if (dl_idx == IDX_W'(i)) begin
                                s_d.rdata = s_q.dl[i][HALF-1:0];
                                s_d.hold  = s_q.dl[i][TIME_W-1:HALF];
                            end
                        end
                    end
                end
            endcase
        end
        s_d.pend = ((s_q.pend & ~w1c) | hit) & ~cxl;
        s_d.en   = s_d.en & ~cxl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bus_rdata = s_q.rdata;
    assign irq       = |(s_q.pend & s_q.en);

    for (genvar i = 0; i < NUM_DL; i++) begin : g_chk
        // R5 / R6: a live hit leaves the pending bit set unless cancelled
        a_r5_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[i] && !cxl[i]) |=> s_q.pend[i]);
        // R11: cancel leaves neither enable nor pending
        a_r11_cancel_clears: assert property (@(posedge clk) disable iff (!rst_n)
            cxl[i] |=> (!s_q.pend[i] && !s_q.en[i]));
        if (i < NUM_DL - 1) begin : g_copy
            // R10: copy takes the neighbour's previous value
            a_r10_copy_down: assert property (@(posedge clk) disable iff (!rst_n)
                (acc_wr && bus_addr == OFS_COPY && bus_wdata[i])
                |=> s_q.dl[i] == $past(s_q.dl[i+1]));
        end
    end
    // R9: relative set of deadline 0 adds the offset to the time base
    a_r9_rel_set: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && bus_addr == OFS_DLBASE + 8'h04)
        |=> s_q.dl[0] == $past(time_q) + {{HALF{1'b0}}, $past(bus_wdata)});
endmodule

// File: tb/rt_deadline_timer_test.sv
`timescale 1ns/1ps
module rt_deadline_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rt_deadline_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    // behavioural reference
    bit [15:0] m_pcnt, m_rld;
    bit        m_run;
    bit [63:0] m_time;
    bit [63:0] m_dl [4];
    bit [3:0]  m_en, m_pend;
    bit [31:0] m_hold, m_rdata;

    always @(posedge clk) begin
        bit [63:0] o_dl [4];
        bit [63:0] o_time;
        bit [3:0]  hits, clr, cx;
        int k;
        if (!rst_n) begin
            m_pcnt = 0; m_rld = 0; m_run = 0; m_time = 0; m_en = 0;
            m_pend = 0; m_hold = 0; m_rdata = 0;
            for (int j = 0; j < 4; j++) m_dl[j] = 0;
        end else begin
            o_time = m_time;
            for (int j = 0; j < 4; j++) o_dl[j] = m_dl[j];
            hits = 0; clr = 0; cx = 0;
            for (int j = 0; j < 4; j++) hits[j] = m_en[j] && (o_time >= o_dl[j]);
            if (m_run) begin
                if (m_pcnt == 0) begin m_time = o_time + 1; m_pcnt = m_rld; end
                else m_pcnt = m_pcnt - 1;
            end
            if (bus_sel && bus_wr) begin
                k = (bus_addr - 8'h80) / 8;
                case (bus_addr)
                    8'h00: m_pcnt = bus_wdata[15:0];
                    8'h04: m_rld = bus_wdata[15:0];
                    8'h0C: m_run = bus_wdata[0];
                    8'h24: m_en = bus_wdata[3:0];
                    8'h28: clr = bus_wdata[3:0];
                    8'h2C: for (int j = 0; j < 3; j++) if (bus_wdata[j]) m_dl[j] = o_dl[j+1];
                    8'h30: cx = bus_wdata[3:0];
                    8'h40: m_hold = bus_wdata;
                    default: if (bus_addr >= 8'h80 && bus_addr < 8'hA0) begin
                        if (bus_addr[2]) m_dl[k] = o_time + {32'b0, bus_wdata};
                        else m_dl[k] = {m_hold, bus_wdata};
                    end
                endcase
            end else if (bus_sel) begin
                k = (bus_addr - 8'h80) / 8;
                case (bus_addr)
                    8'h00: m_rdata = {16'b0, m_pcnt_prev(m_pcnt)};
                    default: m_rdata = 0;
                endcase
                case (bus_addr)
                    8'h04: m_rdata = {16'b0, m_rld};
                    8'h08: m_rdata = 4;
                    8'h0C: m_rdata = {31'b0, m_run};
                    8'h24: m_rdata = {28'b0, m_en};
                    8'h28: m_rdata = {28'b0, m_pend};
                    8'h40: m_rdata = m_hold;
                    default: if (bus_addr >= 8'h80 && bus_addr < 8'hA0 && !bus_addr[2]) begin
                        m_rdata = o_dl[k][31:0];
                        m_hold = o_dl[k][63:32];
                    end
                endcase
            end
            m_pend = ((m_pend & ~clr) | hits) & ~cx;
            m_en = m_en & ~cx;
        end
    end

    // the prescaler read returns the value before this edge's update
    bit [15:0] pcnt_before;
    always @(negedge clk) pcnt_before = m_pcnt;
    function automatic bit [15:0] m_pcnt_prev(bit [15:0] unused);
        return pcnt_before;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R7: irq compared against the model on every cycle
    always @(negedge clk) begin
        if (rst_n && !done) chk("R7 irq", {63'b0, irq}, {63'b0, |(m_pend & m_en)});
    end

    task automatic wr(input bit [7:0] a, input bit [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input bit [7:0] a, input string tag);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(negedge clk);
        bus_sel = 0;
        chk(tag, {32'b0, bus_rdata}, {32'b0, m_rdata});
    endtask

    task automatic rd_exp(input bit [7:0] a, input bit [31:0] e, input string tag);
        rd(a, tag);
        chk({tag, " fixed"}, {32'b0, bus_rdata}, {32'b0, e});
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            failures++; checks++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R12: reset values and reads of write-only offsets
        rd_exp(8'h00, 0, "R12 pcnt");
        rd_exp(8'h0C, 0, "R12 ctrl");
        rd_exp(8'h28, 0, "R12 pend");
        rd_exp(8'h2C, 0, "R12 copy reads zero");
        rd_exp(8'h30, 0, "R12 cancel reads zero");
        rd_exp(8'h84, 0, "R12 set reads zero");
        // R4: read-only info
        rd_exp(8'h08, 4, "R4 info");
        wr(8'h08, 32'hFF);
        rd_exp(8'h08, 4, "R4 info after write");
        // R2: reload width
        wr(8'h04, 32'hFFFF_FFFF);
        rd_exp(8'h04, 32'h0000_FFFF, "R2 reload clip");
        wr(8'h04, 3);
        // R1: countdown and reload
        wr(8'h00, 2);
        wr(8'h0C, 1);
        for (int i = 0; i < 6; i++) rd(8'h00, "R1 prescaler");
        // R3: stopped counter holds
        wr(8'h0C, 0);
        rd(8'h00, "R3 hold a");
        idle(5);
        rd(8'h00, "R3 hold b");
        wr(8'h04, 0);
        wr(8'h0C, 1);
        // R8: holding register path
        wr(8'h40, 32'h0000_0001);
        wr(8'h80, 32'h0000_0005);
        wr(8'h40, 0);
        rd_exp(8'h80, 32'h5, "R8 low word");
        rd_exp(8'h40, 32'h1, "R8 hold latched");
        // R9: relative set and hit
        wr(8'h8C, 20);
        wr(8'h24, 4'b0010);
        rd_exp(8'h28, 0, "R5 not yet");
        idle(30);
        rd_exp(8'h28, 4'b0010, "R5 pending set");
        chk("R7 irq high", {63'b0, irq}, 64'd1);
        // R6: clear during a persisting hit keeps pending
        wr(8'h28, 4'b0010);
        rd_exp(8'h28, 4'b0010, "R6 hit wins");
        wr(8'h24, 0);
        chk("R7 irq masked", {63'b0, irq}, 64'd0);
        wr(8'h28, 4'b0010);
        rd_exp(8'h28, 0, "R6 w1c");
        // R10: copy down and last bit inert
        wr(8'h40, 32'hABCD);
        wr(8'h98, 32'h1234);
        wr(8'h2C, 4'b0001);
        rd(8'h80, "R10 copy low");
        rd(8'h40, "R10 copy high");
        wr(8'h2C, 4'b1000);
        rd_exp(8'h98, 32'h1234, "R10 last inert");
        rd_exp(8'h40, 32'hABCD, "R10 last inert high");
        // R11: cancel
        wr(8'h94, 0);
        wr(8'h24, 4'b0100);
        idle(3);
        rd_exp(8'h28, 4'b0100, "R11 pre pending");
        wr(8'h30, 4'b0100);
        rd_exp(8'h28, 0, "R11 pend cleared");
        rd_exp(8'h24, 0, "R11 enable cleared");
        idle(5);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule